// File: doc/BRIEF.md
# Flag-Driven Sample Concealment

This block sits after the error-correction stage of a digital audio path. Each sample arrives with a flag that marks it as uncorrectable. The block replaces each flagged sample before the sample reaches the output. A run of one to three flagged samples is filled on a straight line between the good sample before the run and the good sample after it. A run of four or more flagged samples is forced to zero until the next good sample arrives, and that good sample is passed through as it is.

Left and right samples share one input stream. A channel-select input steers each sample into its own lane. Each lane has its own four-sample look-ahead window, run state and anchor values, so the two lanes never affect each other. A sample leaves its lane only after four later samples of the same lane have arrived. Every output is tagged with its channel. The output has a valid/ready handshake, and stalling it also stalls the input.

Top module: `sample_conceal`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A sample with in_flag=0 is emitted unchanged. It leaves on the cycle after the accept of the fourth later sample of the same lane, and samples leave in the order they arrived.
- R3: A single flagged sample between good samples A and B is emitted as A + (B−A)/2. The quotient uses signed arithmetic and is truncated toward zero.
- R4: In a run of n=2 or n=3 flagged samples, the sample at position k (1..n) is emitted as A + k·(B−A)/(n+1). The quotient uses signed arithmetic and is truncated toward zero.
- R5: Every sample in a run of four or more consecutive flagged samples is emitted as zero.
- R6: The first good sample after a muted run is emitted unchanged and becomes the left anchor for any later run.
- R7: If a lane has received no good sample before a run, A is taken as zero.
- R8: in_ch=0 selects lane 0 and in_ch=1 selects lane 1. Each output carries its lane in out_ch. The runs and anchors of one lane are not changed by samples of the other lane.
- R9: While out_valid=1 and out_ready=0, in_ready is 0 and out_valid, out_data and out_ch hold their values.
- R10: The data value of a flagged sample has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_ch | input | 1 | Lane select for the input sample |
| in_flag | input | 1 | Sample is uncorrectable |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample |
| out_ch | output | 1 | Lane of the output sample |
| out_data | output | 16 | Signed concealed sample |

## Verification
The main collision is between lanes and the output handshake. A lane can release a filled or muted value in the same cycle that the output is stalled, or the release can go out while the other lane is in the middle of a run. To provoke this, the bench interleaves the two lanes sample by sample and puts different kinds of runs on each lane, with idle gaps between some samples. It then sends the same streams a second time with out_ready dropped on a fixed cadence. Each output is compared in order against a queue. That queue is filled from a whole-stream model that finds each run backward and forward from the sample being checked. Held outputs are compared with the value seen in the stalled cycle.

// File: rtl/conceal_pkg.sv
// Package: shared types for the sample concealment block.
// Assumes: nothing beyond IEEE 1800-2017.
package conceal_pkg;

    // Lane state while the head of the window is released
    typedef enum logic [1:0] {
        ST_PASS = 2'd0,   // no run in progress
        ST_FILL = 2'd1,   // inside a short run being interpolated
        ST_MUTE = 2'd2    // inside a long run being zeroed
    } run_mode_e;

endpackage

// File: rtl/conceal_interp.sv
// Module: conceal_interp
// Computes a + k*(b-a)/(n+1) with signed arithmetic. The quotient is
// truncated toward zero.
// Assumes: 1 <= k <= n, so the result lies between a and b and fits DATA_W.
module conceal_interp #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 3
) (
    input  logic signed [DATA_W-1:0] a_val,
    input  logic signed [DATA_W-1:0] b_val,
    input  logic        [CNT_W-1:0]  run_n,
    input  logic        [CNT_W-1:0]  pos_k,
    output logic signed [DATA_W-1:0] fill_val
);
    localparam int PW = DATA_W + CNT_W + 2;

    logic signed [DATA_W:0] diff;
    logic signed [PW-1:0]   diff_x;
    logic signed [PW-1:0]   k_x;
    logic signed [PW-1:0]   div_x;
    logic signed [PW-1:0]   a_x;
    logic signed [PW-1:0]   prod;

    // Widen all operands to one signed width before multiplying and dividing
    always_comb begin
        diff   = {b_val[DATA_W-1], b_val} - {a_val[DATA_W-1], a_val};
        diff_x = {{(PW-DATA_W-1){diff[DATA_W]}}, diff};
        k_x    = {{(PW-CNT_W){1'b0}}, pos_k};
        div_x  = {{(PW-CNT_W){1'b0}}, run_n} + PW'(1);
        a_x    = {{(PW-DATA_W){a_val[DATA_W-1]}}, a_val};
        prod   = diff_x * k_x;
    end

    // Signed division truncates toward zero
    assign fill_val = DATA_W'(a_x + (prod / div_x));

endmodule

// File: rtl/conceal_lane.sv
// Module: conceal_lane
// One channel lane. It holds a DEPTH-entry window of samples and flags.
// Once the window is full, each push releases the oldest entry. If that
// entry is flagged, it is filled from the anchors or zeroed.
// Assumes: the caller raises push only for samples that belong to this lane.
module conceal_lane
    import conceal_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MAX_RUN = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     in_flag,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     emit,
    output logic signed [DATA_W-1:0] emit_data,
    output logic                     head_flag,
    output logic signed [DATA_W-1:0] head_data,
    output logic                     muting
);
    localparam int DEPTH = MAX_RUN + 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic signed [DATA_W-1:0] win_d [DEPTH];
    logic                     win_f [DEPTH];
    logic [CNT_W-1:0]         fill;
    run_mode_e                mode;
    logic signed [DATA_W-1:0] anchor_a;
    logic signed [DATA_W-1:0] anchor_b;
    logic [CNT_W-1:0]         run_len;
    logic [CNT_W-1:0]         run_pos;

    logic                     full;
    logic [CNT_W-1:0]         lead;
    logic                     lead_stop;
    logic signed [DATA_W-1:0] b_pick;
    logic                     fill_cont;
    logic                     mute_cont;
    logic                     new_mute;
    logic signed [DATA_W-1:0] i_b;
    logic [CNT_W-1:0]         i_n;
    logic [CNT_W-1:0]         i_k;
    logic signed [DATA_W-1:0] fill_val;

    assign full      = (fill == CNT_W'(DEPTH));
    assign emit      = push && full;
    assign head_flag = win_f[0];
    assign head_data = win_d[0];

    // Count the flagged entries at the front of the window
    always_comb begin
        lead      = '0;
        lead_stop = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!lead_stop && win_f[i]) lead = lead + 1'b1;
            else                        lead_stop = 1'b1;
        end
    end

    // Take the good sample that closes a short run starting at the head
    always_comb begin
        b_pick = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) == lead) b_pick = win_d[i];
        end
    end

    // Classify how the head entry is handled
    always_comb begin
        fill_cont = head_flag && (mode == ST_FILL);
        mute_cont = head_flag && (mode == ST_MUTE);
        new_mute  = head_flag && (mode == ST_PASS) && (lead == CNT_W'(DEPTH));
        muting    = mute_cont || new_mute;
    end

    // Choose the interpolator operands for a run in progress or a new run
    always_comb begin
        i_b = fill_cont ? anchor_b : b_pick;
        i_n = fill_cont ? run_len  : lead;
        i_k = fill_cont ? run_pos + 1'b1 : CNT_W'(1);
    end

    conceal_interp #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_interp (
        .a_val    (anchor_a),
        .b_val    (i_b),
        .run_n    (i_n),
        .pos_k    (i_k),
        .fill_val (fill_val)
    );

    // Pick the released value: pass, zero or fill
    always_comb begin
        if (!head_flag)  emit_data = head_data;
        else if (muting) emit_data = '0;
        else             emit_data = fill_val;
    end

    // Shift the window and count entries up to full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                win_d[i] <= '0;
                win_f[i] <= 1'b0;
            end
        end else if (push) begin
            if (!full) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) == fill) begin
                        win_d[i] <= in_data;
                        win_f[i] <= in_flag;
                    end
                end
                fill <= fill + 1'b1;
            end else begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    win_d[i] <= win_d[i+1];
                    win_f[i] <= win_f[i+1];
                end
                win_d[DEPTH-1] <= in_data;
                win_f[DEPTH-1] <= in_flag;
            end
        end
    end

    // Update run mode and anchors as the head leaves the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= ST_PASS;
            anchor_a <= '0;
            anchor_b <= '0;
            run_len  <= '0;
            run_pos  <= '0;
        end else if (emit) begin
            if (!head_flag) begin
                mode     <= ST_PASS;
                anchor_a <= head_data;
            end else if (fill_cont) begin
                run_pos <= run_pos + 1'b1;
            end else if (new_mute) begin
                mode <= ST_MUTE;
            end else if (!mute_cont) begin
                mode     <= ST_FILL;
                anchor_b <= b_pick;
                run_len  <= lead;
                run_pos  <= CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/sample_conceal.sv
// Module: sample_conceal (top)
// Steers each accepted sample to the lane picked by in_ch. A value a lane
// releases is stored in a one-entry output register with a valid/ready
// handshake.
// Assumes: in_ch is below LANES.
module sample_conceal #(
    parameter int DATA_W  = 16,
    parameter int MAX_RUN = 3,
    parameter int LANES   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [$clog2(LANES)-1:0] in_ch,
    input  logic                     in_flag,
    input  logic [DATA_W-1:0]        in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [$clog2(LANES)-1:0] out_ch,
    output logic [DATA_W-1:0]        out_data
);
    localparam int CH_W = $clog2(LANES);

    logic                     accept;
    logic                     lane_emit  [LANES];
    logic signed [DATA_W-1:0] lane_data  [LANES];
    logic                     lane_hflag [LANES];
    logic signed [DATA_W-1:0] lane_hdata [LANES];
    logic                     lane_mute  [LANES];

    logic                     sel_emit;
    logic signed [DATA_W-1:0] sel_data;
    logic                     sel_head_flag;
    logic signed [DATA_W-1:0] sel_head_data;
    logic                     sel_muting;

    assign in_ready = out_ready || !out_valid;
    assign accept   = in_valid && in_ready;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        conceal_lane #(
            .DATA_W  (DATA_W),
            .MAX_RUN (MAX_RUN)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (accept && (in_ch == CH_W'(g))),
            .in_flag   (in_flag),
            .in_data   (in_data),
            .emit      (lane_emit[g]),
            .emit_data (lane_data[g]),
            .head_flag (lane_hflag[g]),
            .head_data (lane_hdata[g]),
            .muting    (lane_mute[g])
        );
    end

    // Select the signals of the addressed lane
    always_comb begin
        sel_emit      = 1'b0;
        sel_data      = '0;
        sel_head_flag = 1'b0;
        sel_head_data = '0;
        sel_muting    = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (in_ch == CH_W'(i)) begin
                sel_emit      = lane_emit[i];
                sel_data      = lane_data[i];
                sel_head_flag = lane_hflag[i];
                sel_head_data = lane_hdata[i];
                sel_muting    = lane_mute[i];
            end
        end
    end

    // Output register: load on release, clear when taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_data  <= '0;
        end else if (accept && sel_emit) begin
            out_valid <= 1'b1;
            out_ch    <= in_ch;
            out_data  <= sel_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/conceal_checker.sv
// Module: conceal_checker
// Properties on the top ports and on the selected lane. It is attached to
// sample_conceal with a bind statement.
// Assumes: synchronous active-low reset.
module conceal_checker #(
    parameter int DATA_W = 16,
    parameter int CH_W   = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic [CH_W-1:0]          in_ch,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [CH_W-1:0]          out_ch,
    input logic [DATA_W-1:0]        out_data,
    input logic                     sel_emit,
    input logic                     sel_head_flag,
    input logic signed [DATA_W-1:0] sel_head_data,
    input logic                     sel_muting
);
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ch)); // R9

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R9

    AST_GOOD_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && sel_emit && !sel_head_flag
        |=> out_valid && (out_data == $past(sel_head_data))); // R2

    AST_LONG_RUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && sel_emit && sel_head_flag && sel_muting
        |=> out_valid && (out_data == '0)); // R5

    AST_CHANNEL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && sel_emit |=> out_ch == $past(in_ch)); // R8

endmodule

bind sample_conceal conceal_checker #(
    .DATA_W (DATA_W),
    .CH_W   ($clog2(LANES))
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_ch         (in_ch),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_ch        (out_ch),
    .out_data      (out_data),
    .sel_emit      (sel_emit),
    .sel_head_flag (sel_head_flag),
    .sel_head_data (sel_head_data),
    .sel_muting    (sel_muting)
);

// File: tb/sample_conceal_test.sv
`timescale 1ns/1ps
module sample_conceal_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [0:0]        in_ch = '0;
    logic              in_flag = 1'b0;
    logic [15:0]       in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [0:0]        out_ch;
    logic [15:0]       out_data;

    int checks = 0;
    int fails  = 0;
    bit bp_on  = 1'b0;
    bit mon_on = 1'b0;
    int cyc    = 0;

    logic signed [15:0] exp_d_q [$];
    logic               exp_c_q [$];
    string              exp_t_q [$];

    logic signed [15:0] hist_d [2][0:255];
    bit                 hist_f [2][0:255];
    int                 hist_n [2];

    logic signed [15:0] st_d [2][0:63];
    bit                 st_f [2][0:63];
    int                 st_n [2];

    always #2 clk = ~clk;

    sample_conceal uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ch(in_ch), .in_flag(in_flag), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_ch(out_ch), .out_data(out_data));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Whole-stream model: finds the run around sample i of lane ln
    function automatic void model(input int ln, input int i,
                                  output logic signed [15:0] v, output string tag);
        int s, len, prod, av, bv;
        bit all4;
        if (!hist_f[ln][i]) begin
            v = hist_d[ln][i];
            tag = "R2";
            if (i >= 4) begin
                all4 = 1'b1;
                for (int j = i - 4; j < i; j++) if (!hist_f[ln][j]) all4 = 1'b0;
                if (all4) tag = "R6";
            end
            return;
        end
        s = i;
        while (s > 0 && hist_f[ln][s-1]) s--;
        len = 0;
        while (len < 4 && hist_f[ln][s+len]) len++;
        if (i - s >= 3 || len == 4) begin
            v = '0;
            tag = "R5";
            return;
        end
        av = (s > 0) ? int'(hist_d[ln][s-1]) : 0;
        bv = int'(hist_d[ln][s+len]);
        prod = (i - s + 1) * (bv - av);
        v = 16'(av + prod / (len + 1));
        if (s == 0)        tag = "R7";
        else if (len == 1) tag = "R3 R10";
        else               tag = "R4 R10";
    endfunction

    task automatic add(input int ln, input bit f, input int d);
        st_d[ln][st_n[ln]] = f ? 16'(16'h5a5a ^ (st_n[ln] * 977)) : 16'(d);
        st_f[ln][st_n[ln]] = f;
        st_n[ln]++;
    endtask

    // Driver: offer one sample, record it, queue any value it releases
    task automatic send(input int ln, input bit f, input logic signed [15:0] d);
        logic signed [15:0] v;
        string t;
        @(negedge clk);
        in_valid = 1'b1;
        in_ch    = 1'(ln);
        in_flag  = f;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        hist_d[ln][hist_n[ln]] = d;
        hist_f[ln][hist_n[ln]] = f;
        hist_n[ln]++;
        if (hist_n[ln] > 4) begin
            model(ln, hist_n[ln] - 5, v, t);
            exp_d_q.push_back(v);
            exp_c_q.push_back(1'(ln));
            exp_t_q.push_back(t);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic play();
        int mx;
        mx = (st_n[0] > st_n[1]) ? st_n[0] : st_n[1];
        for (int j = 0; j < mx; j++) begin
            for (int ln = 0; ln < 2; ln++)
                if (j < st_n[ln]) send(ln, st_f[ln][j], st_d[ln][j]);
            if (j % 7 == 3) idle();
        end
        idle();
    endtask

    // Downstream ready pattern, changed just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            out_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
        end
    end

    // Monitor: stall hold check and scoreboard compare
    logic               prev_stall = 1'b0;
    logic signed [15:0] held_d;
    logic               held_c;
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_stall) begin
                chk(out_valid && out_data == held_d && out_ch == held_c,
                    "R9 hold", longint'($signed(out_data)), longint'(held_d));
            end
            prev_stall = out_valid && !out_ready;
            if (prev_stall) begin
                held_d = out_data;
                held_c = out_ch;
                chk(!in_ready, "R9 in_ready", longint'(in_ready), 0);
            end
            if (out_valid && out_ready) begin
                if (exp_d_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected output", longint'($signed(out_data)), 0);
                end else begin
                    chk($signed(out_data) == exp_d_q[0], exp_t_q[0],
                        longint'($signed(out_data)), longint'(exp_d_q[0]));
                    chk(out_ch == exp_c_q[0], "R8 channel",
                        longint'(out_ch), longint'(exp_c_q[0]));
                    void'(exp_d_q.pop_front());
                    void'(exp_c_q.pop_front());
                    void'(exp_t_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        hist_n[0] = 0; hist_n[1] = 0; st_n[0] = 0; st_n[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R1 out_valid", longint'(out_valid), 0);
        chk(in_ready,   "R1 in_ready",  longint'(in_ready), 1);
        mon_on = 1'b1;

        // Lane 0: single, double, rounding, triple, long runs
        add(0, 0, 100); add(0, 1, 0); add(0, 0, 301);
        add(0, 0, 10);  add(0, 1, 0); add(0, 1, 0); add(0, 0, 40);
        add(0, 0, -7);  add(0, 1, 0); add(0, 0, 0);
        add(0, 0, 1000); add(0, 1, 0); add(0, 1, 0); add(0, 1, 0); add(0, 0, -1000);
        add(0, 0, 5);
        for (int k = 0; k < 4; k++) add(0, 1, 0);
        add(0, 0, 77);
        add(0, 0, 9);
        for (int k = 0; k < 6; k++) add(0, 1, 0);
        add(0, 0, -3);
        add(0, 1, 0); add(0, 1, 0); add(0, 1, 0); add(0, 0, -30);
        for (int k = 0; k < 4; k++) add(0, 0, 11 * k - 20);
        // Lane 1: run at stream start, extremes, long run
        add(1, 1, 0); add(1, 1, 0); add(1, 0, 21);
        add(1, 0, 50); add(1, 1, 0); add(1, 0, 51);
        for (int k = 0; k < 5; k++) add(1, 1, 0);
        add(1, 0, 8);
        add(1, 0, -32768); add(1, 1, 0); add(1, 0, 32767);
        add(1, 0, -1); add(1, 1, 0); add(1, 1, 0); add(1, 0, -2);
        for (int k = 0; k < 4; k++) add(1, 0, 3 - k);

        play();
        repeat (10) @(negedge clk);
        chk(exp_d_q.size() == 0, "R2 drained", longint'(exp_d_q.size()), 0);

        bp_on = 1'b1;
        play();
        repeat (20) @(negedge clk);
        bp_on = 1'b0;
        repeat (10) @(negedge clk);
        chk(exp_d_q.size() == 0, "R2 drained after stall", longint'(exp_d_q.size()), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule